// File: doc/BRIEF.md
# Conference Audio Mixer with Gain-Tracked Output Slice

This block combines up to N signed PCM talker samples, one set per sample period, into a single 14-bit signed output for a conference bridge. The talkers are added at full precision in an accumulator that is wider than the output. A 14-bit window of that accumulator is then chosen by a gain tracker and driven out. If the sum does not fit the window, the output saturates at the nearest limit.

The gain tracker adds up the magnitude of every mixed sum over a block of 256 samples. At the end of each block it picks a new bit offset for the output window from the block's average magnitude. The number of active talkers also caps the offset, so that a mix of few talkers never reads bits that cannot carry signal. In loudest-pair mode only the two active inputs with the largest magnitudes are added.

The interface is a valid strobe with a packed vector of samples, an active-talker count and a mode bit. The output is a 14-bit sample with its own valid strobe. There is no backpressure.

Top module: `talker_mixer`

## Requirements
- R1: With loud2 low, the mix is the exact signed sum of the active inputs, held in an accumulator of IW+log2(N) bits (18 bits by default). Input i occupies in_pcm[i*IW +: IW].
- R2: Inputs whose index is equal to or greater than `talkers` are ignored: they do not affect the output or the gain tracker.
- R3: out_pcm equals the mix arithmetically shifted right by s (bits [s+13:s]), where s = min(offset register, cap). The cap is IW-14+ceil(log2(k)). Here k is `talkers` (clamped to N, and to 2 when loud2 is high), and k = 0 counts as 1.
- R4: A shifted mix above 8191 gives 8191, and one below -8192 gives -8192. The output never wraps.
- R5: The offset register changes only when the 256th sample of a window completes. The first sample that uses the new offset is the one that follows it.
- R6: The new offset is the smallest s in 0..(accumulator width - 14) for which (window magnitude total / 256) >> s is below 4096 (half of the 14-bit full scale). If no s qualifies, the largest value is used.
- R7: With loud2 high, the mix is the sum of the two active inputs with the largest magnitudes. On equal magnitudes the lower index is chosen. With one active input, only that input is used.
- R8: out_valid is high for exactly one cycle per accepted sample, in the second cycle after the cycle in which in_valid was high. This holds for back-to-back samples too.
- R9: A synchronous reset clears out_valid, out_pcm, the window total and the window count, and loads the offset register with its largest value (the accumulator MSBs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new sample set is present this cycle |
| in_pcm | input | N*IW | Packed signed talker samples, input 0 in the low bits |
| talkers | input | $clog2(N+1) | Number of active talkers, counting from input 0 |
| loud2 | input | 1 | Mix only the two loudest active talkers |
| out_valid | output | 1 | out_pcm holds a new mixed sample |
| out_pcm | output | 14 | Signed mixed output sample |

## Verification
Each mixed sample is due in the second cycle after its in_valid cycle. One register stage forms the sum and a second stage shifts and clips it. The bench drives inputs on falling edges and reads out_valid and out_pcm on the second falling edge after the strobe, and it checks that out_valid is low on the falling edge in between. An offset change is due only after a complete window of 256 accepted samples. The bench's reference model therefore applies a new offset starting with sample 257, and the checks placed just before and just after that boundary pin down the exact sample where the slice moves.

// File: rtl/talker_mixer.sv
module talker_mixer #(
  parameter int N      = 4,
  parameter int IW     = 16,
  parameter int OW     = 14,
  parameter int WIN_LG = 8
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [N*IW-1:0]        in_pcm,
  input  logic [$clog2(N+1)-1:0] talkers,
  input  logic                   loud2,
  output logic                   out_valid,
  output logic [OW-1:0]          out_pcm
);
  localparam int NW   = (N > 1) ? $clog2(N) : 1;
  localparam int AW   = IW + NW;
  localparam int SMAX = AW - OW;
  localparam int OFW  = (SMAX > 0) ? $clog2(SMAX + 1) : 1;
  localparam int CW   = $clog2(N + 1);
  localparam int WSW  = AW + WIN_LG;
  localparam int HALF = 1 << (OW - 2);
  localparam logic signed [AW-1:0] PMAX = AW'((1 << (OW - 1)) - 1);
  localparam logic signed [AW-1:0] NMIN = AW'(-(1 << (OW - 1)));

  logic signed [IW-1:0] smp [N];
  logic        [IW:0]   mag [N];

  for (genvar g = 0; g < N; g++) begin : g_in
    assign smp[g] = in_pcm[g*IW +: IW];
    assign mag[g] = smp[g][IW-1] ? (-{smp[g][IW-1], smp[g]}) : {1'b0, smp[g]};
  end

  logic signed [AW-1:0] full_sum, pair_sum, mix;
  int                   i1, i2;
  logic                 h1, h2;
  logic [CW-1:0]        keff;
  int                   lg;
  logic [OFW-1:0]       cap;

  always_comb begin
    full_sum = '0;
    for (int i = 0; i < N; i++)
      if (i < int'(talkers)) full_sum = full_sum + AW'(smp[i]);
    h1 = 1'b0;
    i1 = 0;
    for (int i = 0; i < N; i++)
      if (i < int'(talkers) && (!h1 || mag[i] > mag[i1])) begin
        h1 = 1'b1;
        i1 = i;
      end
    h2 = 1'b0;
    i2 = 0;
    for (int i = 0; i < N; i++)
      if (i < int'(talkers) && i != i1 && (!h2 || mag[i] > mag[i2])) begin
        h2 = 1'b1;
        i2 = i;
      end
    pair_sum = (h1 ? AW'(smp[i1]) : '0) + (h2 ? AW'(smp[i2]) : '0);
    mix = loud2 ? pair_sum : full_sum;
    keff = (talkers > CW'(N)) ? CW'(N) : talkers;
    if (loud2 && keff > CW'(2)) keff = CW'(2);
    if (keff == '0) keff = CW'(1);
    lg = 0;
    for (int j = 0; j <= NW; j++)
      if ((1 << j) < int'(keff)) lg = j + 1;
    cap = OFW'(IW - OW + lg);
  end

  logic                 v1_q;
  logic signed [AW-1:0] sum_q;
  logic [OFW-1:0]       cap_q;
  logic [OFW-1:0]       off_q;
  logic [WSW-1:0]       wsum;
  logic [WIN_LG-1:0]    wcnt;

  logic [OFW-1:0]       s_eff;
  logic signed [AW-1:0] shifted;
  logic [OW-1:0]        sat;
  logic [AW-1:0]        absq;
  logic [WSW-1:0]       tot, avg;
  logic [OFW-1:0]       pick;

  assign s_eff   = (off_q < cap_q) ? off_q : cap_q;
  assign shifted = sum_q >>> s_eff;
  assign sat     = (shifted > PMAX) ? PMAX[OW-1:0] :
                   (shifted < NMIN) ? NMIN[OW-1:0] : shifted[OW-1:0];
  assign absq    = sum_q[AW-1] ? -sum_q : sum_q;
  assign tot     = wsum + WSW'(absq);
  assign avg     = tot >> WIN_LG;

  always_comb begin
    pick = OFW'(SMAX);
    for (int s = SMAX; s >= 0; s--)
      if ((avg >> s) < WSW'(HALF)) pick = OFW'(s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      sum_q     <= '0;
      cap_q     <= '0;
      out_valid <= 1'b0;
      out_pcm   <= '0;
    end else begin
      v1_q      <= in_valid;
      out_valid <= v1_q;
      if (in_valid) begin
        sum_q <= mix;
        cap_q <= cap;
      end
      if (v1_q) out_pcm <= sat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wsum  <= '0;
      wcnt  <= '0;
      off_q <= OFW'(SMAX);
    end else if (v1_q) begin
      if (&wcnt) begin
        off_q <= pick;
        wsum  <= '0;
        wcnt  <= '0;
      end else begin
        wsum <= tot;
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/talker_mixer_chk.sv
module talker_mixer_chk #(
  parameter int AW  = 18,
  parameter int OW  = 14,
  parameter int OFW = 3,
  parameter int WL  = 8
)(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_pcm,
  input logic [AW-1:0] sum_q,
  input logic [OFW-1:0] off,
  input logic [WL-1:0] cnt,
  input logic          v1
);
  localparam int SMAX = AW - OW;

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pcm[OW-1] == $past(sum_q[AW-1])));

  a_r5_offset_hold: assert property (@(posedge clk) disable iff (rst)
    (off != $past(off)) |-> $past(v1 && (&cnt)));

  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && off == OFW'(SMAX) && cnt == '0));
endmodule

bind talker_mixer talker_mixer_chk #(.AW(AW), .OW(OW), .OFW(OFW), .WL(WIN_LG)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_pcm(out_pcm), .sum_q(sum_q), .off(off_q), .cnt(wcnt), .v1(v1_q)
);

// File: tb/talker_mixer_bench.sv
`timescale 1ns/1ps
module talker_mixer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_pcm = '0;
  logic [2:0]  talkers = 3'd4;
  logic        loud2 = 1'b0;
  logic        out_valid;
  logic [13:0] out_pcm;

  int nchk = 0, nfail = 0;
  int moff = 4, mcnt = 0;
  longint msum = 0;

  always #4 clk = ~clk;

  talker_mixer u_talker_mixer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pcm(in_pcm),
    .talkers(talkers), .loud2(loud2), .out_valid(out_valid), .out_pcm(out_pcm)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int step(int a, int b, int c, int d, int k, bit two);
    int s[4];
    int mx, i1, i2, kk, lg, cp, se, sh, mg1, mg2, avg;
    bit h1, h2;
    s[0] = a; s[1] = b; s[2] = c; s[3] = d;
    mx = 0;
    if (!two) begin
      for (int i = 0; i < 4; i++) if (i < k) mx += s[i];
    end else begin
      h1 = 0; h2 = 0; i1 = 0; i2 = 0;
      for (int i = 0; i < k && i < 4; i++) begin
        mg1 = (s[i] < 0) ? -s[i] : s[i];
        mg2 = (s[i1] < 0) ? -s[i1] : s[i1];
        if (!h1 || mg1 > mg2) begin h1 = 1; i1 = i; end
      end
      for (int i = 0; i < k && i < 4; i++) begin
        mg1 = (s[i] < 0) ? -s[i] : s[i];
        mg2 = (s[i2] < 0) ? -s[i2] : s[i2];
        if (i != i1 && (!h2 || mg1 > mg2)) begin h2 = 1; i2 = i; end
      end
      if (h1) mx += s[i1];
      if (h2) mx += s[i2];
    end
    kk = (k > 4) ? 4 : k;
    if (two && kk > 2) kk = 2;
    if (kk == 0) kk = 1;
    lg = (kk <= 1) ? 0 : (kk == 2) ? 1 : 2;
    cp = 2 + lg;
    se = (moff < cp) ? moff : cp;
    sh = mx >>> se;
    if (sh > 8191) sh = 8191;
    if (sh < -8192) sh = -8192;
    msum += (mx < 0) ? -mx : mx;
    if (mcnt == 255) begin
      avg = int'(msum >> 8);
      moff = 4;
      for (int t = 4; t >= 0; t--) if ((avg >>> t) < 4096) moff = t;
      msum = 0;
      mcnt = 0;
    end else mcnt++;
    return sh;
  endfunction

  task automatic drive(int a, int b, int c, int d, int k, bit two);
    in_pcm   = {16'(d), 16'(c), 16'(b), 16'(a)};
    talkers  = 3'(k);
    loud2    = two;
    in_valid = 1'b1;
  endtask

  task automatic send(int a, int b, int c, int d, int k, bit two, string req, output int got);
    int e;
    @(negedge clk);
    drive(a, b, c, d, k, two);
    e = step(a, b, c, d, k, two);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    got = int'($signed(out_pcm));
    chk(out_valid === 1'b1, req, int'(out_valid), 1);
    chk(got == e, req, got, e);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    moff = 4; mcnt = 0; msum = 0;
    chk(out_valid === 1'b0, "R9 valid", int'(out_valid), 0);
    chk(out_pcm === 14'd0, "R9 data", int'(out_pcm), 0);
  endtask

  task automatic t_first_offset();
    int g;
    send(30000, 30000, 30000, 30000, 4, 0, "R9 offset at MSBs", g);
    chk(g == 7500, "R9 literal", g, 7500);
  endtask

  task automatic t_latency();
    int e1, e2;
    send(160, 0, 0, 0, 4, 0, "R8 single", e1);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 one pulse", int'(out_valid), 0);
    drive(1600, 0, 0, 0, 4, 0);
    e1 = step(1600, 0, 0, 0, 4, 0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 not early", int'(out_valid), 0);
    drive(-3200, 0, 0, 0, 4, 0);
    e2 = step(-3200, 0, 0, 0, 4, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R8 b2b first", int'(out_valid), 1);
    chk(int'($signed(out_pcm)) == e1, "R8 b2b first data", int'($signed(out_pcm)), e1);
    @(negedge clk);
    chk(out_valid === 1'b1, "R8 b2b second", int'(out_valid), 1);
    chk(int'($signed(out_pcm)) == e2, "R8 b2b second data", int'($signed(out_pcm)), e2);
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 idle", int'(out_valid), 0);
  endtask

  task automatic t_full_mix();
    int g;
    send(100, 200, 300, 400, 4, 0, "R1 positive", g);
    chk(g == 62, "R1 literal", g, 62);
    send(-1, -1, -1, -1, 4, 0, "R1 arith shift", g);
    chk(g == -1, "R1 literal neg", g, -1);
    send(-32768, -32768, -32768, -32768, 4, 0, "R1 most negative", g);
    chk(g == -8192, "R1 literal min", g, -8192);
  endtask

  task automatic t_mask();
    int g;
    send(1000, 2000, 30000, -30000, 2, 0, "R2 masked inputs", g);
    chk(g == 375, "R2 literal", g, 375);
    send(20000, 9999, 9999, 9999, 1, 0, "R3 cap one talker", g);
    chk(g == 5000, "R3 literal", g, 5000);
    send(5, 5, 5, 5, 0, 0, "R2 none active", g);
    chk(g == 0, "R2 zero talkers", g, 0);
  endtask

  task automatic t_loud2();
    int g;
    send(8000, 3000, -3000, 100, 4, 1, "R7 tie lower index", g);
    chk(g == 1375, "R7 literal", g, 1375);
    send(-100, 200, -9000, 8000, 4, 1, "R7 negative loudest", g);
    chk(g == -125, "R7 literal neg", g, -125);
    send(4000, 30000, 30000, 30000, 1, 1, "R7 single talker", g);
    chk(g == 1000, "R7 literal single", g, 1000);
  endtask

  task automatic t_window();
    int g;
    for (int n = 0; n < 256; n++) send(0, 0, 0, 0, 4, 0, "R5 quiet window", g);
    send(5000, 5000, 5000, 5000, 4, 0, "R4 clip high", g);
    chk(g == 8191, "R4 literal high", g, 8191);
    send(-5000, -5000, -5000, -5000, 4, 0, "R4 clip low", g);
    chk(g == -8192, "R4 literal low", g, -8192);
    for (int n = 0; n < 254; n++) send(2500, 2500, 2500, 2500, 4, 0, "R5 offset held", g);
    chk(g == 8191, "R5 last sample of window", g, 8191);
    send(2500, 2500, 2500, 2500, 4, 0, "R6 retuned offset", g);
    chk(g == 2500, "R6 literal", g, 2500);
  endtask

  initial begin
    t_reset();
    t_first_offset();
    t_latency();
    t_full_mix();
    t_mask();
    t_loud2();
    t_reset();
    t_window();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule